// File: doc/BRIEF.md
# Operand Byte Translator

This block sits on the read data path between memory and an 8-bit processor. When translation is active, every operand byte that the processor reads is rewritten by a selectable bit transform before it reaches the processor. Bytes fetched as opcodes always pass through unaltered, so the program's own instruction stream stays readable. The available transforms are a parity reduction, binary-to-Gray conversion and an exchange of the upper and lower halves of the byte. Because operands are rewritten once translation is on, software must store them pre-transformed.

Translation is switched on through a control register that is written over its own port. The write port carries the raw, untranslated data. Switching on takes two writes. An arm write raises an interrupt-block output. At least one opcode fetch must then take place. Only after that does an enable write start translation and drop the interrupt block. An interrupt therefore cannot land between the two configuration steps. Any write with the enable bit clear always turns translation off, so software can reach the register again in every state.

Control word layout: bits [3:0] hold the transform select, bit 4 is the arm bit and bit 5 is the enable bit. Transform select values: 0 pass, 1 parity, 2 Gray, 3 half swap, 4 to 15 reserved.

Top module: `operand_xlate`

## Requirements
- R1: During reset and right after it, `irq_block` is 0 and translation is off, so every read returns `mem_rdata` unchanged.
- R2: A read with `opfetch`=1 always returns `mem_rdata` unchanged, whatever the state.
- R3: While `rd_en`=0, `cpu_rdata` equals `mem_rdata`.
- R4: With select 1 active, an operand read returns the XOR of all eight bits in bit 0, with bits 7:1 zero.
- R5: With select 2 active, an operand read returns b ^ (b >> 1).
- R6: With select 3 active, an operand read returns {b[3:0], b[7:4]}.
- R7: With select 0 or a reserved select (4 to 15) active, operand reads return b unchanged.
- R8: From the off state, a write with bit 4 = 1 and bit 5 = 0 sets `irq_block` to 1 from the next cycle. Translation stays off.
- R9: While armed, a write with bit 5 = 1 that follows at least one opcode fetch (`rd_en`=1, `opfetch`=1) starts translation with select bits [3:0]. It also clears `irq_block` from the next cycle.
- R10: While armed, a write with bit 5 = 1 before any opcode fetch is ignored. `irq_block` stays 1 and reads stay untranslated.
- R11: A write with bit 5 = 1 is ignored when not armed. From the off state nothing changes. While active, the select already in use is kept.
- R12: While active, a write with bit 5 = 0 turns translation off from the next cycle. If bit 4 = 1, the same write also re-arms and raises `irq_block`.
- R13: While armed, a write with bits 5:4 = 00 aborts. It releases `irq_block`, and a later enable write is then ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_rdata | input | 8 | Read data from memory |
| opfetch | input | 1 | High when the current read is an opcode fetch |
| rd_en | input | 1 | Read strobe |
| ctrl_we | input | 1 | Control register write strobe (already address-decoded) |
| ctrl_wdata | input | 8 | Raw control word |
| cpu_rdata | output | 8 | Read data delivered to the processor |
| irq_block | output | 1 | High while interrupts must be held off |

## Verification
The checker watches these rules on every cycle: opcode fetches and idle bus cycles pass data unchanged, `irq_block` only rises on an arm write, translation only starts after an arm with an observed opcode fetch, an early enable write never releases the block, and a disable write always stops translation. The bench covers the rest. It sweeps all 256 byte values under every transform select, including the reserved ones, and runs the arm, abort, early-enable and re-arm sequences. Those results only show up as data values over whole sequences.

// File: rtl/otx_pkg.sv
package otx_pkg;
  localparam int MODE_W = 4;

  typedef enum logic [MODE_W-1:0] {
    XM_PASS   = 4'd0,
    XM_PARITY = 4'd1,
    XM_GRAY   = 4'd2,
    XM_SWAP   = 4'd3
  } otx_mode_e;

  typedef enum logic [1:0] {
    XS_IDLE   = 2'd0,
    XS_ARMED  = 2'd1,
    XS_ACTIVE = 2'd2
  } otx_state_e;
endpackage

// File: rtl/otx_xform.sv
module otx_xform
  import otx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] din,
  input  logic [MODE_W-1:0] mode,
  output logic [DATA_W-1:0] dout
);
  localparam int HALF = DATA_W / 2;

  logic [DATA_W-1:0] gray_w;
  logic [DATA_W-1:0] swap_w;
  logic [DATA_W-1:0] par_w;

  genvar i;
  generate
    for (i = 0; i < DATA_W; i++) begin : g_bit
      if (i == DATA_W - 1) begin : g_top
        assign gray_w[i] = din[i];
      end else begin : g_low
        assign gray_w[i] = din[i] ^ din[i+1];
      end
      if (i < HALF) begin : g_lo_half
        assign swap_w[i] = din[i+HALF];
      end else begin : g_hi_half
        assign swap_w[i] = din[i-HALF];
      end
    end
  endgenerate

  assign par_w = {{(DATA_W-1){1'b0}}, ^din};

  always_comb begin
    case (mode)
      XM_PARITY: dout = par_w;
      XM_GRAY:   dout = gray_w;
      XM_SWAP:   dout = swap_w;
      default:   dout = din;
    endcase
  end
endmodule

// File: rtl/otx_ctrl.sv
module otx_ctrl
  import otx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_we,
  input  logic [DATA_W-1:0] ctrl_wdata,
  input  logic              rd_en,
  input  logic              opfetch,
  output logic              active,
  output logic              armed,
  output logic              fetch_seen,
  output logic [MODE_W-1:0] mode
);
  localparam int ARM_BIT = MODE_W;
  localparam int GO_BIT  = MODE_W + 1;

  otx_state_e        state_q, state_d;
  logic              seen_q, seen_d;
  logic [MODE_W-1:0] mode_q, mode_d;
  logic              arm_b, go_b, op_fetch, upd_en;

  assign arm_b    = ctrl_wdata[ARM_BIT];
  assign go_b     = ctrl_wdata[GO_BIT];
  assign op_fetch = rd_en & opfetch;
  assign upd_en   = ctrl_we | op_fetch;

  always_comb begin
    state_d = state_q;
    seen_d  = seen_q;
    mode_d  = mode_q;
    if (state_q == XS_ARMED && op_fetch) seen_d = 1'b1;
    if (ctrl_we) begin
      case (state_q)
        XS_IDLE: begin
          if (arm_b && !go_b) begin
            state_d = XS_ARMED;
            seen_d  = 1'b0;
          end
        end
        XS_ARMED: begin
          if (go_b) begin
            if (seen_q) begin
              state_d = XS_ACTIVE;
              mode_d  = ctrl_wdata[MODE_W-1:0];
              seen_d  = 1'b0;
            end
          end else if (arm_b) begin
            seen_d = 1'b0;
          end else begin
            state_d = XS_IDLE;
            seen_d  = 1'b0;
          end
        end
        XS_ACTIVE: begin
          if (!go_b) begin
            mode_d  = XM_PASS;
            seen_d  = 1'b0;
            state_d = arm_b ? XS_ARMED : XS_IDLE;
          end
        end
        default: begin
          state_d = XS_IDLE;
          mode_d  = XM_PASS;
          seen_d  = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= XS_IDLE;
      seen_q  <= 1'b0;
      mode_q  <= XM_PASS;
    end else if (upd_en) begin
      state_q <= state_d;
      seen_q  <= seen_d;
      mode_q  <= mode_d;
    end
  end

  assign active     = (state_q == XS_ACTIVE);
  assign armed      = (state_q == XS_ARMED);
  assign fetch_seen = seen_q;
  assign mode       = mode_q;
endmodule

// File: rtl/operand_xlate.sv
module operand_xlate
  import otx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              opfetch,
  input  logic              rd_en,
  input  logic              ctrl_we,
  input  logic [DATA_W-1:0] ctrl_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              irq_block
);
  logic [1:0]        rst_pipe_q;
  logic              rst_sync_n;
  logic              active;
  logic              armed;
  logic              fetch_seen;
  logic [MODE_W-1:0] mode;
  logic [DATA_W-1:0] xf_out;
  logic              do_xlate;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  otx_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .ctrl_we    (ctrl_we),
    .ctrl_wdata (ctrl_wdata),
    .rd_en      (rd_en),
    .opfetch    (opfetch),
    .active     (active),
    .armed      (armed),
    .fetch_seen (fetch_seen),
    .mode       (mode)
  );

  otx_xform #(.DATA_W(DATA_W)) u_xform (
    .din  (mem_rdata),
    .mode (mode),
    .dout (xf_out)
  );

  assign do_xlate  = active & rd_en & ~opfetch;
  assign cpu_rdata = do_xlate ? xf_out : mem_rdata;
  assign irq_block = armed;
endmodule

// File: rtl/operand_xlate_chk.sv
module operand_xlate_chk #(
  parameter int DATA_W = 8,
  parameter int MODE_W = 4
) (
  input logic              clk,
  input logic              rst_ni,
  input logic [DATA_W-1:0] mem_rdata,
  input logic              opfetch,
  input logic              rd_en,
  input logic              ctrl_we,
  input logic [DATA_W-1:0] ctrl_wdata,
  input logic [DATA_W-1:0] cpu_rdata,
  input logic              irq_block,
  input logic              active,
  input logic              fetch_seen
);
  localparam int ARM_BIT = MODE_W;
  localparam int GO_BIT  = MODE_W + 1;

  // R1
  always @(posedge clk) begin
    if (!rst_ni) begin
      reset_quiet_chk: assert (!irq_block && !active);
    end
  end

  // R2
  opc_passthru_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (rd_en && opfetch) |-> (cpu_rdata == mem_rdata));

  // R3
  idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !rd_en |-> (cpu_rdata == mem_rdata));

  // R8
  arm_source_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(irq_block) |-> $past(ctrl_we && ctrl_wdata[ARM_BIT] && !ctrl_wdata[GO_BIT]));

  // R9
  enable_gate_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(active) |-> $past(irq_block && fetch_seen && ctrl_we && ctrl_wdata[GO_BIT]));

  // R10
  early_go_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (irq_block && !fetch_seen && ctrl_we && ctrl_wdata[GO_BIT]) |=> irq_block);

  // R12
  disable_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (active && ctrl_we && !ctrl_wdata[GO_BIT]) |=> !active);
endmodule

bind operand_xlate operand_xlate_chk #(.DATA_W(DATA_W), .MODE_W(otx_pkg::MODE_W)) u_chk (
  .clk        (clk),
  .rst_ni     (rst_sync_n),
  .mem_rdata  (mem_rdata),
  .opfetch    (opfetch),
  .rd_en      (rd_en),
  .ctrl_we    (ctrl_we),
  .ctrl_wdata (ctrl_wdata),
  .cpu_rdata  (cpu_rdata),
  .irq_block  (irq_block),
  .active     (active),
  .fetch_seen (fetch_seen)
);

// File: tb/operand_xlate_tb.sv
`timescale 1ns/1ps
module operand_xlate_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] mem_rdata = 8'h00;
  logic       opfetch = 1'b0;
  logic       rd_en = 1'b0;
  logic       ctrl_we = 1'b0;
  logic [7:0] ctrl_wdata = 8'h00;
  logic [7:0] cpu_rdata;
  logic       irq_block;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 1'b0;

  always #2.5 clk = ~clk;

  operand_xlate u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .mem_rdata  (mem_rdata),
    .opfetch    (opfetch),
    .rd_en      (rd_en),
    .ctrl_we    (ctrl_we),
    .ctrl_wdata (ctrl_wdata),
    .cpu_rdata  (cpu_rdata),
    .irq_block  (irq_block)
  );

  task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] expect_of(input int m, input logic [7:0] b);
    int ones;
    case (m)
      1: begin
        ones = 0;
        for (int k = 0; k < 8; k++) ones += int'(b[k]);
        return 8'(ones % 2);
      end
      2: return b ^ (b >> 1);
      3: return (b << 4) | (b >> 4);
      default: return b;
    endcase
  endfunction

  task automatic wr(input logic [7:0] d);
    @(negedge clk);
    ctrl_we = 1'b1; ctrl_wdata = d; rd_en = 1'b0; opfetch = 1'b0;
    @(negedge clk);
    ctrl_we = 1'b0;
  endtask

  task automatic rd(input logic op, input logic strobe, input logic [7:0] b, output logic [7:0] got);
    @(negedge clk);
    rd_en = strobe; opfetch = op; mem_rdata = b;
    #1 got = cpu_rdata;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] got;
    repeat (4) @(negedge clk);
    // R1: reset state
    chk(irq_block == 1'b0, "R1 reset irq_block", {7'd0, irq_block}, 8'h00);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(irq_block == 1'b0, "R1 post-reset irq_block", {7'd0, irq_block}, 8'h00);
    rd(1'b0, 1'b1, 8'h5A, got);
    chk(got == 8'h5A, "R1 pass-through after reset", got, 8'h5A);

    // R11: enable write while off is ignored
    wr(8'h23);
    chk(irq_block == 1'b0, "R11 go while off irq_block", {7'd0, irq_block}, 8'h00);
    rd(1'b0, 1'b1, 8'h12, got);
    chk(got == 8'h12, "R11 go while off data", got, 8'h12);

    // R8: arm
    wr(8'h10);
    chk(irq_block == 1'b1, "R8 arm irq_block", {7'd0, irq_block}, 8'h01);
    rd(1'b0, 1'b1, 8'h12, got);
    chk(got == 8'h12, "R8 armed data untranslated", got, 8'h12);

    // R10: enable before any opcode fetch is ignored
    wr(8'h23);
    chk(irq_block == 1'b1, "R10 early go irq_block", {7'd0, irq_block}, 8'h01);
    rd(1'b0, 1'b1, 8'h12, got);
    chk(got == 8'h12, "R10 early go data", got, 8'h12);

    // R9: opcode fetch then enable swap
    rd(1'b1, 1'b1, 8'hEA, got);
    wr(8'h23);
    chk(irq_block == 1'b0, "R9 enable releases irq_block", {7'd0, irq_block}, 8'h00);
    rd(1'b0, 1'b1, 8'h12, got);
    chk(got == 8'h21, "R9 swap active", got, 8'h21);

    // R11: enable write while active keeps select
    wr(8'h22);
    rd(1'b0, 1'b1, 8'h12, got);
    chk(got == 8'h21, "R11 go while active keeps select", got, 8'h21);

    // R12: re-arm from active
    wr(8'h10);
    chk(irq_block == 1'b1, "R12 re-arm irq_block", {7'd0, irq_block}, 8'h01);
    rd(1'b0, 1'b1, 8'h12, got);
    chk(got == 8'h12, "R12 re-arm stops translation", got, 8'h12);

    // R13: abort while armed
    wr(8'h00);
    chk(irq_block == 1'b0, "R13 abort irq_block", {7'd0, irq_block}, 8'h00);
    rd(1'b1, 1'b1, 8'hEA, got);
    wr(8'h23);
    rd(1'b0, 1'b1, 8'h12, got);
    chk(got == 8'h12, "R13 enable after abort ignored", got, 8'h12);

    // Sweep every select over every byte value
    for (int m = 0; m < 16; m++) begin
      string tag;
      tag = (m == 1) ? "R4 parity" : (m == 2) ? "R5 gray" : (m == 3) ? "R6 swap" : "R7 pass/reserved";
      wr(8'h10);
      rd(1'b1, 1'b1, 8'hEA, got);
      wr(8'h20 | 8'(m));
      chk(irq_block == 1'b0, "R9 enable in sweep", {7'd0, irq_block}, 8'h00);
      for (int b = 0; b < 256; b++) begin
        logic [7:0] exp_v;
        exp_v = expect_of(m, 8'(b));
        rd(1'b0, 1'b1, 8'(b), got);
        chk(got == exp_v, tag, got, exp_v);
        rd(1'b1, 1'b1, 8'(b), got);
        chk(got == 8'(b), "R2 opcode unchanged", got, 8'(b));
        rd(1'b0, 1'b0, 8'(b), got);
        chk(got == 8'(b), "R3 no strobe unchanged", got, 8'(b));
      end
      wr(8'h00);
      rd(1'b0, 1'b1, 8'h1E, got);
      chk(got == 8'h1E, "R12 disable", got, 8'h1E);
      chk(irq_block == 1'b0, "R12 disable irq_block", {7'd0, irq_block}, 8'h00);
    end

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule